// File: doc/BRIEF.md
# Microcode Branch Condition Unit

This block forms the one-bit test signal that a microcode sequencer uses to decide a conditional branch. It offers two condition paths. The immediate path picks one of eight conditions from the current cycle, optionally inverts it, and presents it at once as the test bit. The deferred path picks one of eight conditions with its own select field and its own invert bit, and stores the result in a one-bit flag register on every rising clock edge.

The stored flag is one of the immediate path's choices. Microcode can therefore latch a condition in one microinstruction and branch on it in a later one. The deferred path can also select the flag's own value, which lets the microcode hold the flag over several cycles or toggle it. The flag is also driven out of the block so that it can feed the ALU's shift or carry input.

All pins are plain control and status signals. Neither path carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `bc_branch_cond`

## Requirements
- R1: With `rst` high at a rising clock edge, `flag_q` is 0 after that edge (synchronous, active-high reset).
- R2: With `br_sel` = 0, `test_out` equals 1 when `br_inv` = 0 and 0 when `br_inv` = 1.
- R3: With `br_sel` = 1, `test_out` equals `flag_q` XOR `br_inv`.
- R4: Branch select codes 2, 3, 4 and 5 route `alu_zero`, `alu_carry`, `alu_ovf` and `alu_sign` respectively to `test_out`, XORed with `br_inv`.
- R5: Branch select codes 6 and 7 route `ctl_stat_a` and `ctl_stat_b` respectively to `test_out`, XORed with `br_inv`.
- R6: `test_out` is combinational: it reflects the present inputs and the present `flag_q` in the same cycle, with no clock edge in between.
- R7: With `rst` low and `fl_sel` = 0, `flag_q` after the edge is 1 when `fl_inv` = 0 and 0 when `fl_inv` = 1.
- R8: With `rst` low and `fl_sel` = 1, `flag_q` keeps its value across the edge when `fl_inv` = 0 and inverts when `fl_inv` = 1.
- R9: Flag select codes 2 and 3 load `shift_lo` and `shift_hi` respectively into `flag_q`, XORed with `fl_inv`.
- R10: Flag select codes 4, 5, 6 and 7 load `alu_zero`, `alu_carry`, `alu_ovf` and `alu_sign` respectively into `flag_q`, XORed with `fl_inv`.
- R11: `flag_q` updates on every rising edge with no enable. A flag loaded in one cycle is visible through `br_sel` = 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flag |
| br_sel | input | 3 | Immediate condition select |
| br_inv | input | 1 | Inverts the immediate condition |
| fl_sel | input | 3 | Deferred (flag) condition select |
| fl_inv | input | 1 | Inverts the deferred condition before it is stored |
| alu_zero | input | 1 | ALU zero status |
| alu_carry | input | 1 | ALU carry status |
| alu_ovf | input | 1 | ALU overflow status |
| alu_sign | input | 1 | ALU sign status |
| shift_lo | input | 1 | First ALU shift-register output bit |
| shift_hi | input | 1 | Second ALU shift-register output bit |
| ctl_stat_a | input | 1 | First external controller status line |
| ctl_stat_b | input | 1 | Second external controller status line |
| test_out | output | 1 | Test bit to the sequencer |
| flag_q | output | 1 | Registered flag, also used as an ALU shift/carry source |

## Verification
The hardest case to reach is the flag's self-loop: a stored value that is held or toggled over several edges and then tested through `br_sel` = 1. It is only visible if the value written earlier differs from what a reset or a fresh load would give. The stimulus first loads a known value from a shift bit. It then runs chains of hold and toggle cycles while reading the flag back through the immediate path. After that come long stretches of random control fields, with both select fields often pointing at the flag. A behavioural model compares `test_out` and `flag_q` on every cycle.

// File: rtl/bc_pkg.sv
package bc_pkg;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned N_COND = 1 << SEL_W;

  // Immediate-path condition slots
  typedef enum logic [SEL_W-1:0] {
    BR_ONE   = 3'd0,
    BR_FLAG  = 3'd1,
    BR_ZERO  = 3'd2,
    BR_CARRY = 3'd3,
    BR_OVF   = 3'd4,
    BR_SIGN  = 3'd5,
    BR_CTLA  = 3'd6,
    BR_CTLB  = 3'd7
  } br_cond_e;

  // Deferred-path condition slots
  typedef enum logic [SEL_W-1:0] {
    FL_ONE   = 3'd0,
    FL_SELF  = 3'd1,
    FL_SHLO  = 3'd2,
    FL_SHHI  = 3'd3,
    FL_ZERO  = 3'd4,
    FL_CARRY = 3'd5,
    FL_OVF   = 3'd6,
    FL_SIGN  = 3'd7
  } fl_cond_e;

  typedef struct packed {
    logic zero;
    logic carry;
    logic ovf;
    logic sign;
  } alu_stat_t;
endpackage

// File: rtl/bc_cond_select.sv
module bc_cond_select #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N = 1 << SEL_W
) (
  input  logic [N-1:0]     conds,
  input  logic [SEL_W-1:0] sel,
  input  logic             inv,
  output logic             y
);
  logic [N-1:0] hit;
  logic         picked;

  // One-hot decode of the select, then an OR reduction.
  for (genvar g = 0; g < N; g++) begin : g_dec
    assign hit[g] = (sel == SEL_W'(g)) & conds[g];
  end

  always_comb begin
    picked = |hit;
    y      = picked ^ inv;
  end
endmodule

// File: rtl/bc_flag_stage.sv
module bc_flag_stage
  import bc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] fl_sel,
  input  logic             fl_inv,
  input  logic             shift_lo,
  input  logic             shift_hi,
  input  alu_stat_t        alu,
  output logic             flag_q
);
  logic [N_COND-1:0] fconds;
  logic              fnext;

  always_comb begin
    fconds           = '0;
    fconds[FL_ONE]   = 1'b1;
    fconds[FL_SELF]  = flag_q;
    fconds[FL_SHLO]  = shift_lo;
    fconds[FL_SHHI]  = shift_hi;
    fconds[FL_ZERO]  = alu.zero;
    fconds[FL_CARRY] = alu.carry;
    fconds[FL_OVF]   = alu.ovf;
    fconds[FL_SIGN]  = alu.sign;
  end

  bc_cond_select #(.SEL_W(SEL_W)) u_fsel (
    .conds(fconds),
    .sel  (fl_sel),
    .inv  (fl_inv),
    .y    (fnext)
  );

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= fnext;
  end

  // Checks on the flag register
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !flag_q);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (fl_sel == FL_SELF && !fl_inv) |=> $stable(flag_q));
  p_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    (fl_sel == FL_SELF && fl_inv) |=> (flag_q != $past(flag_q)));
  p_const_r7: assert property (@(posedge clk) disable iff (rst)
    (fl_sel == FL_ONE) |=> (flag_q == !$past(fl_inv)));
  p_shift_lo_r9: assert property (@(posedge clk) disable iff (rst)
    (fl_sel == FL_SHLO) |=> (flag_q == ($past(shift_lo) ^ $past(fl_inv))));
endmodule

// File: rtl/bc_branch_cond.sv
module bc_branch_cond
  import bc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] br_sel,
  input  logic       br_inv,
  input  logic [2:0] fl_sel,
  input  logic       fl_inv,
  input  logic       alu_zero,
  input  logic       alu_carry,
  input  logic       alu_ovf,
  input  logic       alu_sign,
  input  logic       shift_lo,
  input  logic       shift_hi,
  input  logic       ctl_stat_a,
  input  logic       ctl_stat_b,
  output logic       test_out,
  output logic       flag_q
);
  alu_stat_t         alu;
  logic [N_COND-1:0] bconds;

  assign alu = '{zero: alu_zero, carry: alu_carry, ovf: alu_ovf, sign: alu_sign};

  bc_flag_stage u_flag (
    .clk     (clk),
    .rst     (rst),
    .fl_sel  (fl_sel),
    .fl_inv  (fl_inv),
    .shift_lo(shift_lo),
    .shift_hi(shift_hi),
    .alu     (alu),
    .flag_q  (flag_q)
  );

  always_comb begin
    bconds           = '0;
    bconds[BR_ONE]   = 1'b1;
    bconds[BR_FLAG]  = flag_q;
    bconds[BR_ZERO]  = alu.zero;
    bconds[BR_CARRY] = alu.carry;
    bconds[BR_OVF]   = alu.ovf;
    bconds[BR_SIGN]  = alu.sign;
    bconds[BR_CTLA]  = ctl_stat_a;
    bconds[BR_CTLB]  = ctl_stat_b;
  end

  bc_cond_select #(.SEL_W(SEL_W)) u_bsel (
    .conds(bconds),
    .sel  (br_sel),
    .inv  (br_inv),
    .y    (test_out)
  );

  // Checks relating the two paths and the ports
  p_always_r2: assert property (@(posedge clk) disable iff (rst)
    (br_sel == BR_ONE) |-> (test_out == !br_inv));
  p_flag_route_r3: assert property (@(posedge clk) disable iff (rst)
    (br_sel == BR_FLAG) |-> (test_out == (flag_q ^ br_inv)));
  p_latched_test_r11: assert property (@(posedge clk) disable iff (rst)
    (fl_sel == FL_ZERO && !fl_inv) ##1 (br_sel == BR_FLAG && !br_inv && !rst)
      |-> (test_out == $past(alu_zero)));
  p_ctl_b_r5: assert property (@(posedge clk) disable iff (rst)
    (br_sel == BR_CTLB) |-> (test_out == (ctl_stat_b ^ br_inv)));
endmodule

// File: tb/bc_branch_cond_bench.sv
`timescale 1ns/1ps
module bc_branch_cond_bench;
  logic clk = 1'b0;
  logic rst;
  logic [2:0] br_sel, fl_sel;
  logic br_inv, fl_inv;
  logic alu_zero, alu_carry, alu_ovf, alu_sign;
  logic shift_lo, shift_hi, ctl_stat_a, ctl_stat_b;
  logic test_out, flag_q;

  int checks = 0;
  int errors = 0;
  int model_flag = -1;  // -1: unknown before first reset edge
  bit done = 0;

  always #2 clk = ~clk;

  bc_branch_cond u_bc_branch_cond (
    .clk(clk), .rst(rst),
    .br_sel(br_sel), .br_inv(br_inv), .fl_sel(fl_sel), .fl_inv(fl_inv),
    .alu_zero(alu_zero), .alu_carry(alu_carry), .alu_ovf(alu_ovf), .alu_sign(alu_sign),
    .shift_lo(shift_lo), .shift_hi(shift_hi),
    .ctl_stat_a(ctl_stat_a), .ctl_stat_b(ctl_stat_b),
    .test_out(test_out), .flag_q(flag_q)
  );

  function automatic string br_req(input int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2, 3, 4, 5: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic string fl_req(input int s);
    case (s)
      0: return "R7";
      1: return "R8";
      2, 3: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic int exp_test();
    int c;
    case (br_sel)
      3'd0: c = 1;
      3'd1: c = model_flag;
      3'd2: c = alu_zero;
      3'd3: c = alu_carry;
      3'd4: c = alu_ovf;
      3'd5: c = alu_sign;
      3'd6: c = ctl_stat_a;
      default: c = ctl_stat_b;
    endcase
    return c ^ int'(br_inv);
  endfunction

  function automatic int next_flag();
    int c;
    if (rst) return 0;
    case (fl_sel)
      3'd0: c = 1;
      3'd1: c = model_flag;
      3'd2: c = shift_lo;
      3'd3: c = shift_hi;
      3'd4: c = alu_zero;
      3'd5: c = alu_carry;
      3'd6: c = alu_ovf;
      default: c = alu_sign;
    endcase
    return c ^ int'(fl_inv);
  endfunction

  // Check after inputs settle, mid-cycle; then advance the model at the edge.
  string last_flag_req = "R1";
  task automatic step(input logic [2:0] bs, input logic bi, input logic [2:0] fs,
                      input logic fi, input logic [9:0] st, input logic r);
    int e;
    @(negedge clk);
    br_sel = bs; br_inv = bi; fl_sel = fs; fl_inv = fi; rst = r;
    {alu_zero, alu_carry, alu_ovf, alu_sign, shift_lo, shift_hi,
     ctl_stat_a, ctl_stat_b} = st[7:0];
    #1;
    if (model_flag >= 0) begin
      checks++;
      if (int'(flag_q) !== model_flag) begin
        errors++;
        $display("FAIL %s/R11 flag_q actual=%b expected=%0d", last_flag_req, flag_q, model_flag);
      end
      if (!(bs == 3'd1 && model_flag < 0)) begin
        e = exp_test();
        checks++;
        if (int'(test_out) !== e) begin
          errors++;
          $display("FAIL %s/R6 test_out sel=%0d inv=%b actual=%b expected=%0d",
                   br_req(bs), bs, bi, test_out, e);
        end
      end
    end
    last_flag_req = r ? "R1" : fl_req(fs);
    @(posedge clk);
    model_flag = next_flag();
  endtask

  initial begin
    rst = 1; br_sel = 0; br_inv = 0; fl_sel = 0; fl_inv = 0;
    {alu_zero, alu_carry, alu_ovf, alu_sign, shift_lo, shift_hi, ctl_stat_a, ctl_stat_b} = '0;
    // R1: reset, with flag select trying to set the flag
    step(3'd0, 0, 3'd0, 0, 10'h0, 1);
    step(3'd0, 0, 3'd0, 0, 10'h0, 1);
    step(3'd1, 0, 3'd0, 0, 10'h0, 0);  // flag 0 here (R1), then loads 1 (R7)
    step(3'd1, 0, 3'd0, 1, 10'h0, 0);  // flag 1 read via R3, loads 0
    step(3'd0, 1, 3'd1, 0, 10'h0, 0);  // R2 never-branch, hold
    // R9: load from shift_lo=1, then hold and toggle chain, read via R3
    step(3'd1, 0, 3'd2, 0, 10'b0000001000, 0);
    for (int i = 0; i < 4; i++) step(3'd1, 0, 3'd1, 0, 10'h0, 0);
    for (int i = 0; i < 5; i++) step(3'd1, 1, 3'd1, 1, 10'h0, 0);
    step(3'd1, 0, 3'd3, 1, 10'b0000000100, 0);  // shift_hi inverted
    // R4/R5 walk each single status bit through every branch code
    for (int b = 0; b < 8; b++)
      for (int s = 0; s < 8; s++) begin
        step(3'(s), 1'(b & 1), 3'(4 + (b & 3)), 1'(b >> 2), 10'(1 << b), 0);
      end
    // R10: each ALU flag into the register, observed next cycle via R3
    for (int f = 4; f < 8; f++) begin
      step(3'd1, 0, 3'(f), 0, 10'(8'h80 >> (f - 4)), 0);
      step(3'd1, 0, 3'(f), 1, 10'(8'h80 >> (f - 4)), 0);
      step(3'd1, 0, 3'd1, 0, 10'h0, 0);
    end
    // Random mix, including mid-run resets
    for (int i = 0; i < 3000; i++)
      step(3'($urandom), 1'($urandom), 3'($urandom), 1'($urandom), 10'($urandom),
           ($urandom % 50) == 0);
    step(3'd1, 0, 3'd1, 0, 10'h0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule